// File: doc/BRIEF.md
# Planar Video Memory Write Datapath

This block sits between a CPU data port and a video memory built as four byte-wide planes. It turns one written CPU byte into four plane bytes and four plane write enables. It also keeps one latch byte per plane, which is filled from memory when the CPU reads.

A two-bit mode field selects how the CPU-side byte for each plane is formed. In standard mode the CPU byte is rotated right. Then, for each plane, it may be replaced by all zeros or all ones under per-plane set/reset control. In color-expansion mode, bit n of the CPU byte is widened to a full byte for plane n. This mode skips both the rotation and the set/reset controls. From that point every mode uses the same path. A per-plane logic unit combines the byte with the plane's latch. A bit mask then picks, bit by bit, between that result and the latch. Finally a map mask gates the write enable of each plane.

The plane outputs are combinational from the inputs and the latches. Only the latches are clocked.

Top module: `planar_write_path`

## Requirements
- R1: After reset all four latches are 0x00, and `planeWe` is 0 whenever `cpuWrite` is low.
- R2: In standard mode (`writeMode` 00, and also 01 or 11), the CPU byte is rotated right by `rotCount` (0..7) before set/reset is applied.
- R3: In standard mode, plane n takes 0xFF when `srEnable[n]`=1 and `srValue[n]`=1. It takes 0x00 when `srEnable[n]`=1 and `srValue[n]`=0. It takes the rotated CPU byte when `srEnable[n]`=0.
- R4: In color-expansion mode (`writeMode` 10), CPU bit n (n = 0..3) gives 0xFF for plane n when it is 1 and 0x00 when it is 0. CPU bits 7..4 have no effect.
- R5: In color-expansion mode, `rotCount`, `srEnable` and `srValue` have no effect.
- R6: The logic unit of each plane outputs one of four values selected by `logicSel`: 00 gives the CPU-side byte unchanged, 01 gives the CPU-side byte AND the latch, 10 gives them ORed, and 11 gives them XORed.
- R7: For each bit position, a `bitMask` bit of 1 takes the logic unit bit and a 0 takes the latch bit. This applies to every plane.
- R8: While `cpuWrite` is high, `planeWe[n]` equals `mapMask[n]`.
- R9: On a clock edge with `cpuRead` high, latch n loads `memData[8n+7:8n]`. Otherwise the latches hold, including across writes.
- R10: When a read and a write happen in the same cycle, the write uses the latch values from before that cycle's load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuData | input | 8 | CPU write byte |
| cpuWrite | input | 1 | Write strobe for this cycle |
| cpuRead | input | 1 | Read strobe; loads the latches at the clock edge |
| writeMode | input | 2 | Write mode select (10 = color expansion, others = standard) |
| rotCount | input | 3 | Right rotation count for standard mode |
| logicSel | input | 2 | Logic unit function select |
| srEnable | input | 4 | Per-plane set/reset enable |
| srValue | input | 4 | Per-plane set/reset value |
| bitMask | input | 8 | Per-bit select: 1 = logic result, 0 = latch |
| mapMask | input | 4 | Per-plane write permit |
| memData | input | 32 | Four plane bytes at the read address, plane n in bits 8n+7:8n |
| planeData | output | 32 | Four plane write bytes, plane n in bits 8n+7:8n |
| planeWe | output | 4 | Per-plane write enable |

## Verification
A read and a write can fall in the same cycle. In that case the latch load and the write merge both touch the latch value. The bench first loads known latches. It then raises both strobes at once with new memory data and a zero bit mask. Before the edge, the written bytes must still show the old latches. After the edge, a plain write must show the new memory data. The remaining functions are swept across every mode, rotation count, logic function and set/reset enable pattern, using several data bytes and masks. Each result is compared with a reference computed arithmetically from the requirements.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  localparam int PLANES = 4;
  localparam int BYTE_W = 8;
  localparam int ROT_W  = $clog2(BYTE_W);
  localparam int BUS_W  = PLANES * BYTE_W;

  typedef enum logic [1:0] {
    LOP_PASS = 2'b00,
    LOP_AND  = 2'b01,
    LOP_OR   = 2'b10,
    LOP_XOR  = 2'b11
  } lop_e;

  localparam logic [1:0] MODE_EXPAND = 2'b10;

  typedef struct packed {
    logic              expandMode;
    logic              loadLatch;
    logic [PLANES-1:0] planeWe;
  } pwp_ctrl_t;
endpackage

// File: rtl/pwp_ctrl.sv
module pwp_ctrl
  import pwp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        writeMode,
  input  logic              cpuWrite,
  input  logic              cpuRead,
  input  logic [PLANES-1:0] mapMask,
  output pwp_ctrl_t         ctrl
);
  always_comb begin
    ctrl.expandMode = (writeMode == MODE_EXPAND);
    ctrl.loadLatch  = cpuRead;
    ctrl.planeWe    = cpuWrite ? mapMask : '0;
  end

  // R8: no plane is enabled unless the map mask permits it
  p_we_in_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.planeWe & ~mapMask) == '0);
endmodule

// File: rtl/pwp_datapath.sv
module pwp_datapath
  import pwp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] cpuData,
  input  logic [ROT_W-1:0]  rotCount,
  input  logic [1:0]        logicSel,
  input  logic [PLANES-1:0] srEnable,
  input  logic [PLANES-1:0] srValue,
  input  logic [BYTE_W-1:0] bitMask,
  input  logic [BUS_W-1:0]  memData,
  input  pwp_ctrl_t         ctrl,
  output logic [BUS_W-1:0]  planeData
);
  logic [2*BYTE_W-1:0] rotWide;
  logic [BYTE_W-1:0]   rotated;

  assign rotWide = {cpuData, cpuData} >> rotCount;
  assign rotated = rotWide[BYTE_W-1:0];

  logic [PLANES-1:0][BYTE_W-1:0] latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      latchQ <= '0;
    else if (ctrl.loadLatch)
      latchQ <= memData;
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] srcByte;
    logic [BYTE_W-1:0] aluByte;
    logic [BYTE_W-1:0] outByte;

    always_comb begin
      if (ctrl.expandMode)
        srcByte = {BYTE_W{cpuData[p]}};
      else if (srEnable[p])
        srcByte = {BYTE_W{srValue[p]}};
      else
        srcByte = rotated;
    end

    always_comb begin
      unique case (lop_e'(logicSel))
        LOP_AND: aluByte = srcByte & latchQ[p];
        LOP_OR:  aluByte = srcByte | latchQ[p];
        LOP_XOR: aluByte = srcByte ^ latchQ[p];
        default: aluByte = srcByte;
      endcase
    end

    assign outByte = (aluByte & bitMask) | (latchQ[p] & ~bitMask);
    assign planeData[p*BYTE_W +: BYTE_W] = outByte;

    // R4: expanded pass-through bytes are all zeros or all ones
    p_expand_solid_r4: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.expandMode && logicSel == LOP_PASS && bitMask == '1)
        |-> (outByte == '0 || outByte == '1));

    // R7: an all-zero bit mask writes the latch back unchanged
    p_mask_keeps_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
      (bitMask == '0) |-> (outByte == latchQ[p]));
  end

  // R9: a read strobe loads the latches at the next edge
  p_latch_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadLatch |=> (latchQ == $past(memData)));

  // R9: without a read strobe the latches hold
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadLatch |=> $stable(latchQ));
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
  import pwp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cpuData,
  input  logic              cpuWrite,
  input  logic              cpuRead,
  input  logic [1:0]        writeMode,
  input  logic [2:0]        rotCount,
  input  logic [1:0]        logicSel,
  input  logic [3:0]        srEnable,
  input  logic [3:0]        srValue,
  input  logic [7:0]        bitMask,
  input  logic [3:0]        mapMask,
  input  logic [31:0]       memData,
  output logic [31:0]       planeData,
  output logic [3:0]        planeWe
);
  pwp_ctrl_t ctrl;

  pwp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .writeMode (writeMode),
    .cpuWrite  (cpuWrite),
    .cpuRead   (cpuRead),
    .mapMask   (mapMask),
    .ctrl      (ctrl)
  );

  pwp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuData   (cpuData),
    .rotCount  (rotCount),
    .logicSel  (logicSel),
    .srEnable  (srEnable),
    .srValue   (srValue),
    .bitMask   (bitMask),
    .memData   (memData),
    .ctrl      (ctrl),
    .planeData (planeData)
  );

  assign planeWe = ctrl.planeWe;
endmodule

// File: tb/planar_write_path_tb.sv
`timescale 1ns/1ps
module planar_write_path_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cpuData = '0;
  logic        cpuWrite = 1'b0;
  logic        cpuRead = 1'b0;
  logic [1:0]  writeMode = '0;
  logic [2:0]  rotCount = '0;
  logic [1:0]  logicSel = '0;
  logic [3:0]  srEnable = '0;
  logic [3:0]  srValue = '0;
  logic [7:0]  bitMask = '0;
  logic [3:0]  mapMask = '0;
  logic [31:0] memData = '0;
  logic [31:0] planeData;
  logic [3:0]  planeWe;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] latchModel = '0;

  always #2 clk = ~clk;

  planar_write_path u_dut (
    .clk(clk), .rstN(rstN), .cpuData(cpuData), .cpuWrite(cpuWrite),
    .cpuRead(cpuRead), .writeMode(writeMode), .rotCount(rotCount),
    .logicSel(logicSel), .srEnable(srEnable), .srValue(srValue),
    .bitMask(bitMask), .mapMask(mapMask), .memData(memData),
    .planeData(planeData), .planeWe(planeWe)
  );

  function automatic logic [31:0] refData(
    input logic [7:0] d, input logic [1:0] md, input logic [2:0] rot,
    input logic [1:0] op, input logic [3:0] en, input logic [3:0] val,
    input logic [7:0] bm, input logic [31:0] lat);
    logic [31:0] r;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] src, alu, l, rr;
      l = lat[p*8 +: 8];
      rr = 8'((d >> rot) | (d << (8 - int'(rot))));
      if (md == 2'b10) src = d[p] ? 8'hFF : 8'h00;
      else if (en[p]) src = val[p] ? 8'hFF : 8'h00;
      else src = rr;
      case (op)
        2'b01: alu = src & l;
        2'b10: alu = src | l;
        2'b11: alu = src ^ l;
        default: alu = src;
      endcase
      r[p*8 +: 8] = (alu & bm) | (l & ~bm);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadLatches(input logic [31:0] v);
    @(negedge clk);
    memData = v; cpuRead = 1'b1;
    @(negedge clk);
    cpuRead = 1'b0;
    latchModel = v;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 we idle", {28'd0, planeWe}, 32'd0);
    bitMask = 8'h00; cpuWrite = 1'b1; mapMask = 4'hF;
    #1 check("R1 latch zero", planeData, 32'd0);
    cpuWrite = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 we idle after reset", {28'd0, planeWe}, 32'd0);

    // R8: map mask gating
    for (int m = 0; m < 16; m++) begin
      mapMask = 4'(m); cpuWrite = 1'b1;
      #1 check("R8 we follows mask", {28'd0, planeWe}, 32'(m));
      cpuWrite = 1'b0;
      #1 check("R8 we idle", {28'd0, planeWe}, 32'd0);
    end

    // R9: latch load and hold across writes
    loadLatches(32'hA5C3_3C5A);
    bitMask = 8'h00; cpuWrite = 1'b1; cpuData = 8'hFF;
    repeat (4) @(negedge clk);
    check("R9 latch hold", planeData, 32'hA5C3_3C5A);
    cpuWrite = 1'b0;

    // R2: simple rotation check
    writeMode = 2'b00; srEnable = 4'h0; logicSel = 2'b00; bitMask = 8'hFF;
    cpuData = 8'h01; rotCount = 3'd1;
    #1 check("R2 rotate by one", planeData, 32'h8080_8080);
    rotCount = 3'd4; cpuData = 8'h3C;
    #1 check("R2 rotate by four", planeData, 32'hC3C3_C3C3);

    // R4: upper nibble ignored in expansion
    writeMode = 2'b10;
    for (int hi = 0; hi < 16; hi++) begin
      cpuData = {4'(hi), 4'b1010};
      #1 check("R4 expand nibble", planeData, 32'hFF00_FF00);
    end

    // R5: rotation and set/reset ignored in expansion
    cpuData = 8'h06;
    for (int k = 0; k < 64; k++) begin
      rotCount = 3'(k); srEnable = 4'(k >> 2); srValue = ~4'(k);
      #1 check("R5 expand ignores sr/rot", planeData, 32'h00FF_FF00);
    end

    // R10: same-cycle read and write
    loadLatches(32'h1122_3344);
    @(negedge clk);
    bitMask = 8'h00; memData = 32'hDEAD_BEEF; cpuRead = 1'b1; cpuWrite = 1'b1;
    #1 check("R10 write sees old latch", planeData, 32'h1122_3344);
    @(negedge clk);
    cpuRead = 1'b0; latchModel = 32'hDEAD_BEEF;
    #1 check("R10 new latch after edge", planeData, 32'hDEAD_BEEF);
    cpuWrite = 1'b0;

    // R2 R3 R6 R7 sweep against arithmetic reference
    loadLatches(32'h5AF0_0F96);
    for (int md = 0; md < 4; md++)
      for (int op = 0; op < 4; op++)
        for (int rot = 0; rot < 8; rot++)
          for (int en = 0; en < 16; en++)
            for (int di = 0; di < 4; di++) begin
              logic [7:0] d;
              d = 8'(37 * (di + 1) + en * 11 + rot);
              writeMode = 2'(md); logicSel = 2'(op); rotCount = 3'(rot);
              srEnable = 4'(en); srValue = 4'(en ^ di ^ rot);
              bitMask = 8'(rot * 29 + di * 71 + op);
              cpuData = d;
              #1 check("R2 R3 R6 R7 sweep", planeData,
                refData(d, 2'(md), 3'(rot), 2'(op), 4'(en), 4'(en ^ di ^ rot),
                        8'(rot * 29 + di * 71 + op), latchModel));
              #1;
            end

    finish();
  end
endmodule